// File: doc/BRIEF.md
# Burst-to-PCI Request Translator

This block sits between a memory-mapped master and a PCI initiator. It takes one request at a time: an address, a read/write flag, a burst count, byte enables and write data. It turns the request into a sequence of data-phase descriptors. Each descriptor carries a dword address, a 64-bit request flag, active-low byte enables, write data, a marker for the first phase of a PCI transaction and a marker for the last one.

The datapath width is a parameter, either 32 or 64 bits. On a 64-bit path, a single-beat request is split according to which dword halves have any enable set. A read with both halves enabled first tries a 64-bit phase. If the target does not acknowledge it as 64-bit, the upper half is fetched again as a 32-bit phase. A write with both halves enabled becomes a two-phase 32-bit burst. A disconnect before the final phase makes the block restart at the next dword as a new transaction.

The master holds its request steady while `req_wait` is high. `req_wait` drops one cycle after the final phase has been accepted. For bursts, write data is taken from `req_wdata` as it is presented at that moment. A phase is consumed in any cycle where `ph_valid` and `tgt_accept` are both high.

Top module: `pci_req_xlate`

## Requirements
- R1: On a 32-bit path, a request with burst count 1 gives one phase with ph_start=1, ph_last=1, ph_req64=0 and ph_be_n equal to the bitwise inverse of req_be, for both read and write.
- R2: On a 32-bit path, a read with burst count N>1 gives N phases at consecutive dword addresses (base+4*i), each with ph_be_n=0 (all bytes enabled), and ph_last set only on the final phase.
- R3: On a 32-bit path, a write with burst count N>1 gives N phases at consecutive dword addresses, each with ph_be_n equal to the inverse of req_be and ph_wdata equal to req_wdata.
- R4: On a 64-bit path, a single-beat request with req_be[7:4]=0 gives one phase at the 8-byte-aligned address with ph_req64=0, ph_be_n[3:0]=~req_be[3:0], ph_be_n[7:4]=4'hF, and, for writes, ph_wdata[31:0]=req_wdata[31:0] with ph_wdata[63:32]=0.
- R5: On a 64-bit path, a single-beat request with req_be[3:0]=0 and any upper enable set gives one phase at aligned address+4 with ph_req64=0, ph_be_n[3:0]=~req_be[7:4], ph_be_n[7:4]=4'hF, and, for writes, ph_wdata[31:0]=req_wdata[63:32].
- R6: On a 64-bit path, a single-beat read with enables in both halves first issues one phase with ph_req64=1, ph_last=1, ph_be_n=~req_be, at the aligned address. If tgt_ack64 is high when that phase is accepted, the request completes.
- R7: If that 64-bit read phase is accepted with tgt_ack64 low, the next phase is a new transaction (ph_start=1) at aligned address+4 with ph_req64=0, ph_last=1 and ph_be_n[3:0]=~req_be[7:4].
- R8: On a 64-bit path, a single-beat write with enables in both halves gives two 32-bit phases with ph_req64=0. The first is at the aligned address with the lower enables and data and ph_last=0. The second is at +4 with the upper enables and data, ph_start=0 and ph_last=1.
- R9: A phase accepted with tgt_disc high before the final phase makes the next phase start a new transaction (ph_start=1) at the following dword address. The remaining enables and data are unchanged.
- R10: req_wait is high while req_valid is high, from the request until the cycle after the final phase is accepted. An unaccepted phase holds its address, enables and markers.
- R11: On a 64-bit path, a request with burst count N>1 gives 2*N 32-bit phases. Even phases carry the lower half and odd phases the upper half. Reads have all enables set; writes carry the inverse of the requested enables for that half.
- R12: A burst count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until req_wait is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_burst | input | BCNT_W | Burst count in beats |
| req_be | input | DATA_W/8 | Active-high byte enables |
| req_wdata | input | DATA_W | Write data |
| req_wait | output | 1 | Stall to the master |
| ph_valid | output | 1 | A phase descriptor is presented |
| ph_addr | output | ADDR_W | Dword address of the phase |
| ph_req64 | output | 1 | Phase requests a 64-bit transfer |
| ph_be_n | output | DATA_W/8 | Active-low byte enables |
| ph_wdata | output | DATA_W | Phase write data (zero for reads) |
| ph_start | output | 1 | First phase of a PCI transaction |
| ph_last | output | 1 | Final phase of the PCI transaction |
| tgt_accept | input | 1 | Target completes the current phase |
| tgt_ack64 | input | 1 | Target accepted the phase as 64-bit |
| tgt_disc | input | 1 | Target disconnects after this phase |

## Verification
The assertions rely on the master keeping req_valid and the request fields steady while req_wait is high. They also rely on the target signals being meaningful only in a cycle where a phase is presented. The stimulus respects both: it raises req_valid with a complete request, holds it until it sees req_wait low, and pulses tgt_accept, tgt_ack64 and tgt_disc only against a presented phase. It covers both path widths, stalls of several cycles before acceptance, and disconnects at chosen phase indices.

// File: rtl/pci_req_xlate.sv
module pci_req_xlate #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BCNT_W-1:0] req_burst,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_wait,
  output logic              ph_valid,
  output logic [ADDR_W-1:0] ph_addr,
  output logic              ph_req64,
  output logic [DATA_W/8-1:0] ph_be_n,
  output logic [DATA_W-1:0] ph_wdata,
  output logic              ph_start,
  output logic              ph_last,
  input  logic              tgt_accept,
  input  logic              tgt_ack64,
  input  logic              tgt_disc
);
  localparam int BE_W  = DATA_W / 8;
  localparam int CNT_W = BCNT_W + 2;

  logic busy, done, wide, first, wr_q, rdall_q;
  logic [ADDR_W-1:0] base_q;
  logic [BE_W-1:0]   be_q;
  logic [CNT_W-1:0]  idx, endx;

  logic [CNT_W-1:0] beats, ld_idx, ld_end;
  logic             ld_wide, multi;
  logic [3:0]       be_sel;
  logic [31:0]      dat_sel;
  logic [BE_W-1:0]  nar_be_n;
  logic [DATA_W-1:0] nar_data;

  assign beats = (req_burst == '0) ? CNT_W'(1) : CNT_W'(req_burst);
  assign multi = req_burst > BCNT_W'(1);

  generate
    if (DATA_W == 64) begin : g_w64
      logic lo_on, hi_on;
      assign lo_on = |req_be[3:0];
      assign hi_on = |req_be[7:4];
      always_comb begin
        ld_wide = 1'b0;
        ld_idx  = '0;
        ld_end  = CNT_W'(1);
        if (multi) ld_end = beats << 1;
        else if (!hi_on) ld_end = CNT_W'(1);
        else if (!lo_on) begin
          ld_idx = CNT_W'(1);
          ld_end = CNT_W'(2);
        end else if (req_write) ld_end = CNT_W'(2);
        else ld_wide = 1'b1;
      end
      assign be_sel   = idx[0] ? be_q[7:4] : be_q[3:0];
      assign dat_sel  = idx[0] ? req_wdata[63:32] : req_wdata[31:0];
      assign nar_be_n = {4'hF, rdall_q ? 4'h0 : ~be_sel};
      assign nar_data = {32'd0, wr_q ? dat_sel : 32'd0};
    end else begin : g_w32
      assign ld_wide  = 1'b0;
      assign ld_idx   = '0;
      assign ld_end   = beats;
      assign be_sel   = be_q[3:0];
      assign dat_sel  = req_wdata[31:0];
      assign nar_be_n = rdall_q ? 4'h0 : ~be_sel;
      assign nar_data = wr_q ? dat_sel : 32'd0;
    end
  endgenerate

  assign req_wait = req_valid && !done;
  assign ph_valid = busy;
  assign ph_req64 = busy && wide;
  assign ph_start = busy && first;
  assign ph_last  = busy && (wide || (idx + CNT_W'(1) == endx));
  assign ph_addr  = base_q + (ADDR_W'(idx) << 2);
  assign ph_be_n  = wide ? ~be_q : nar_be_n;
  assign ph_wdata = wide ? (wr_q ? req_wdata : '0) : nar_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; wide <= 1'b0; first <= 1'b0;
      wr_q <= 1'b0; rdall_q <= 1'b0; base_q <= '0; be_q <= '0;
      idx <= '0; endx <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid && !done) begin
          busy    <= 1'b1;
          first   <= 1'b1;
          wide    <= ld_wide;
          wr_q    <= req_write;
          rdall_q <= !req_write && multi;
          base_q  <= req_addr & ~ADDR_W'(BE_W - 1);
          be_q    <= req_be;
          idx     <= ld_idx;
          endx    <= ld_end;
        end
      end else if (tgt_accept) begin
        if (wide) begin
          if (tgt_ack64) begin
            busy <= 1'b0; done <= 1'b1; wide <= 1'b0;
          end else begin
            wide <= 1'b0; idx <= CNT_W'(1); endx <= CNT_W'(2); first <= 1'b1;
          end
        end else if (ph_last) begin
          busy <= 1'b0; done <= 1'b1;
        end else begin
          idx   <= idx + CNT_W'(1);
          first <= tgt_disc;
        end
      end
    end
  end
endmodule

module pci_req_xlate_chk #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_wait,
  input logic              ph_valid,
  input logic [ADDR_W-1:0] ph_addr,
  input logic              ph_req64,
  input logic [BE_W-1:0]   ph_be_n,
  input logic              ph_start,
  input logic              ph_last,
  input logic              tgt_accept,
  input logic              tgt_ack64,
  input logic              tgt_disc
);
  // R6
  wide_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_req64 |-> ph_valid && ph_last);
  // R4
  narrow_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && !ph_req64) |-> ((ph_be_n | BE_W'(15)) == '1));
  // R7
  wide_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && tgt_accept && ph_req64 && !tgt_ack64) |=>
      (ph_valid && ph_start && !ph_req64 && ph_addr == $past(ph_addr) + ADDR_W'(4)));
  // R9
  disc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && tgt_accept && tgt_disc && !ph_last) |=> (ph_valid && ph_start));
  // R10
  hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && !tgt_accept) |=>
      (ph_valid && $stable(ph_addr) && $stable(ph_be_n) && $stable(ph_last) && $stable(ph_req64)));
  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && tgt_accept && ph_last && (!ph_req64 || tgt_ack64)) |=> (!ph_valid && !req_wait));
  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_valid |-> req_wait);
endmodule

bind pci_req_xlate pci_req_xlate_chk #(.ADDR_W(ADDR_W), .BE_W(DATA_W/8)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_wait(req_wait), .ph_valid(ph_valid),
  .ph_addr(ph_addr), .ph_req64(ph_req64), .ph_be_n(ph_be_n),
  .ph_start(ph_start), .ph_last(ph_last), .tgt_accept(tgt_accept),
  .tgt_ack64(tgt_ack64), .tgt_disc(tgt_disc));

// File: tb/pci_req_xlate_tb.sv
module pci_req_xlate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        v64 = 0, v32 = 0, wr = 0;
  logic [31:0] addr = 0;
  logic [7:0]  burst = 0, be = 0;
  logic [63:0] wdata = 0;
  logic        acc = 0, ack = 0, disc = 0;

  logic        w64, pv64, q64_o, st64, la64;
  logic [31:0] pa64;
  logic [7:0]  pb64;
  logic [63:0] pd64;
  logic        w32, pv32, q32_o, st32, la32;
  logic [31:0] pa32;
  logic [3:0]  pb32;
  logic [31:0] pd32;

  pci_req_xlate #(.DATA_W(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(v64), .req_write(wr), .req_addr(addr),
    .req_burst(burst), .req_be(be), .req_wdata(wdata), .req_wait(w64),
    .ph_valid(pv64), .ph_addr(pa64), .ph_req64(q64_o), .ph_be_n(pb64),
    .ph_wdata(pd64), .ph_start(st64), .ph_last(la64),
    .tgt_accept(acc), .tgt_ack64(ack), .tgt_disc(disc));

  pci_req_xlate #(.DATA_W(32)) dut32_i (
    .clk(clk), .rst_n(rst_n), .req_valid(v32), .req_write(wr), .req_addr(addr),
    .req_burst(burst), .req_be(be[3:0]), .req_wdata(wdata[31:0]), .req_wait(w32),
    .ph_valid(pv32), .ph_addr(pa32), .ph_req64(q32_o), .ph_be_n(pb32),
    .ph_wdata(pd32), .ph_start(st32), .ph_last(la32),
    .tgt_accept(acc), .tgt_ack64(ack), .tgt_disc(disc));

  typedef struct {
    logic [31:0] a; bit q; logic [7:0] bn; logic [63:0] d; bit st; bit la;
  } ph_t;
  ph_t exp_q[$];
  int checks = 0, errors = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic ph_t mk(logic [31:0] a, bit q, logic [7:0] bn, logic [63:0] d, bit st, bit la);
    ph_t p; p.a = a; p.q = q; p.bn = bn; p.d = d; p.st = st; p.la = la; return p;
  endfunction

  task automatic build(bit u64, bit w, logic [31:0] a, int bc, logic [7:0] b,
                       logic [63:0] d, int dat, bit ak);
    int beats = (bc == 0) ? 1 : bc;
    exp_q.delete();
    if (!u64) begin
      for (int i = 0; i < beats; i++) begin
        logic [3:0] e = (beats > 1 && !w) ? 4'h0 : ~b[3:0];
        exp_q.push_back(mk((a & ~32'd3) + 4*i, 0, {4'hF, e}, w ? {32'd0, d[31:0]} : 64'd0,
                           i == 0 || dat == i-1, i == beats-1));
      end
    end else begin
      logic [31:0] ba = a & ~32'd7;
      if (beats > 1 || (b[7:4] != 0 && b[3:0] != 0 && w)) begin
        int n = 2*beats;
        for (int i = 0; i < n; i++) begin
          logic [3:0]  hb = (i % 2) ? b[7:4] : b[3:0];
          logic [31:0] hd = (i % 2) ? d[63:32] : d[31:0];
          exp_q.push_back(mk(ba + 4*i, 0, {4'hF, (w ? ~hb : 4'h0)}, w ? {32'd0, hd} : 64'd0,
                             i == 0 || dat == i-1, i == n-1));
        end
      end else if (b[7:4] == 0)
        exp_q.push_back(mk(ba, 0, {4'hF, ~b[3:0]}, w ? {32'd0, d[31:0]} : 64'd0, 1, 1));
      else if (b[3:0] == 0)
        exp_q.push_back(mk(ba + 4, 0, {4'hF, ~b[7:4]}, w ? {32'd0, d[63:32]} : 64'd0, 1, 1));
      else begin
        exp_q.push_back(mk(ba, 1, ~b, 64'd0, 1, 1));
        if (!ak) exp_q.push_back(mk(ba + 4, 0, {4'hF, ~b[7:4]}, 64'd0, 1, 1));
      end
    end
  endtask

  task automatic run(string tag, bit u64, bit w, logic [31:0] a, int bc, logic [7:0] b,
                     logic [63:0] d, int dat, bit ak, int stall);
    int n;
    build(u64, w, a, bc, b, d, dat, ak);
    n = exp_q.size();
    @(negedge clk);
    wr = w; addr = a; burst = 8'(bc); be = b; wdata = d;
    if (u64) v64 = 1; else v32 = 1;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      for (int s = 0; s <= stall; s++) begin
        ph_t e = exp_q[k];
        chk(tag, "valid", u64 ? pv64 : pv32, 1);
        chk("R10", "req_wait", u64 ? w64 : w32, 1);
        chk(tag, "addr", u64 ? pa64 : pa32, e.a);
        chk(tag, "req64", u64 ? q64_o : q32_o, e.q);
        chk(tag, "be_n", u64 ? pb64 : {4'hF, pb32}, e.bn);
        if (w) chk(tag, "data", u64 ? pd64 : {32'd0, pd32}, e.d);
        chk(tag, "start", u64 ? st64 : st32, e.st);
        chk(tag, "last", u64 ? la64 : la32, e.la);
        acc  = (s == stall);
        disc = (s == stall) && (k == dat);
        ack  = (s == stall) && ak;
        @(negedge clk);
      end
    end
    acc = 0; disc = 0; ack = 0;
    chk("R10", "valid after end", u64 ? pv64 : pv32, 0);
    chk("R10", "req_wait after end", u64 ? w64 : w32, 0);
    v64 = 0; v32 = 0;
    @(negedge clk);
    chk("R10", "idle", u64 ? pv64 : pv32, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "reset valid64", pv64, 0);
    chk("R10", "reset valid32", pv32, 0);
    chk("R10", "reset wait64", w64, 0);
    // R1
    run("R1", 0, 0, 32'h1000, 1, 8'h05, 64'h0, -1, 0, 0);
    run("R1", 0, 1, 32'h1004, 1, 8'h0E, 64'hAAAA_BBBB_1234_5678, -1, 0, 1);
    // R2
    run("R2", 0, 0, 32'h2000, 4, 8'h03, 64'h0, -1, 0, 1);
    // R3 with R9 disconnect mid-burst
    run("R3", 0, 1, 32'h3000, 3, 8'h09, 64'h0000_0000_CAFE_F00D, -1, 0, 0);
    run("R9", 0, 1, 32'h3100, 3, 8'h09, 64'h0000_0000_0BAD_BEEF, 1, 0, 0);
    // R12
    run("R12", 0, 1, 32'h3200, 0, 8'h06, 64'h0000_0000_1111_2222, -1, 0, 0);
    // R4
    run("R4", 1, 0, 32'h4008, 1, 8'h0F, 64'h0, -1, 0, 0);
    run("R4", 1, 1, 32'h4010, 1, 8'h03, 64'h9999_8888_7777_6666, -1, 0, 1);
    // R5
    run("R5", 1, 0, 32'h5000, 1, 8'hC0, 64'h0, -1, 0, 0);
    run("R5", 1, 1, 32'h5008, 1, 8'h30, 64'hDEAD_BEEF_0123_4567, -1, 0, 0);
    // R6
    run("R6", 1, 0, 32'h6000, 1, 8'hFF, 64'h0, -1, 1, 1);
    // R7
    run("R7", 1, 0, 32'h6008, 1, 8'h3C, 64'h0, -1, 0, 0);
    // R8
    run("R8", 1, 1, 32'h7000, 1, 8'hF1, 64'h5555_6666_7777_8888, -1, 0, 2);
    // R9
    run("R9", 1, 1, 32'h7010, 1, 8'h81, 64'h1234_5678_9ABC_DEF0, 0, 0, 0);
    // R11
    run("R11", 1, 0, 32'h8000, 2, 8'h11, 64'h0, -1, 0, 0);
    run("R11", 1, 1, 32'h8100, 2, 8'hA5, 64'hFEDC_BA98_7654_3210, 2, 0, 1);
    // R12 on the wide path
    run("R12", 1, 1, 32'h8200, 0, 8'h0C, 64'h0000_0000_4444_5555, -1, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule